// File: doc/BRIEF.md
# Calendar Time Counter

This block keeps wall-clock time and date for a battery-backed clock: seconds, minutes, hours, day of month, month, two-digit year and century. A one-cycle `tick` pulse, once per second, moves the count forward. Every carry is made directly in the encoding that is currently selected, either packed BCD or plain binary. Hours are held in 24-hour form, or in 12-hour form with the afternoon flag in bit 7 of the hour byte.

A host reaches the fields through a byte-wide indirect port. It first writes an offset into the address latch. Each later data-port write lands at that offset, and `data_out` always shows the byte at the latched offset. A control byte selects the encoding and the hour form, and it also holds a freeze bit. While the freeze bit is set, ticks are ignored, so software can load a new time without the count moving under it.

Top module: `rtc_calendar`

## Requirements
- R1: A pulse on `addr_we` latches `addr_in`. A `data_we` pulse writes `data_in` to the register at the latched offset, and `data_out` shows that register's contents. The offsets are: second 0x00, minute 0x02, hour 0x04, day 0x07, month 0x08, year 0x09, century 0x32 and control 0x0B. Any other offset reads as 0x00, and writes to it change nothing.
- R2: After reset the control byte is 0x86 and the fields hold second 0, minute 0, hour 0, day 1, month 1, year 0 and century 20. All of these are binary values.
- R3: Outside a freeze, each `tick` advances the time by one second, so a count released from 00:00:00 reads second 1 after the first tick and second 2 after the second. No field changes without a tick or a host write.
- R4: When control bit 2 is clear, every field is packed BCD and counts from digit 9 into the next tens digit. For example, 0x09 becomes 0x10 and 0x59 wraps to 0x00 with a carry.
- R5: When control bit 2 is set, every field is binary and counts up to the same limits: second and minute 59, hour 23, month 12, year 99.
- R6: When control bit 1 is set, the hour runs from 0 to 23 and carries into the day on wrapping.
- R7: When control bit 1 is clear, the hour runs 12, 1, …, 11. Bit 7 is the afternoon flag and toggles when 11 becomes 12. 12 PM becomes 1 PM, and 11 PM becomes 12 AM with a carry into the day. In BCD, 0x11:59:59 becomes 0x92:00:00.
- R8: The day wraps to 1 after the last day of the month. April, June, September and November have 30 days, and February has 29 in a leap year and 28 otherwise. A year is a leap year when it is divisible by 4 and is not 00, or when it is 00 and the century is divisible by 4.
- R9: Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and carries into the century, and century 99 wraps to 0.
- R10: While control bit 7 is set, ticks have no effect on any field.
- R11: A host data write in the same cycle as a tick takes effect, and that tick is dropped entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Once-per-second advance pulse |
| addr_we | input | 1 | Latch `addr_in` as the current offset |
| addr_in | input | ADDR_W | Offset to latch |
| data_we | input | 1 | Write `data_in` at the latched offset |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Contents of the register at the latched offset |

## Verification
The host data write and the tick can arrive in the same cycle. The bench arranges this by latching the minute offset, then raising `data_we` and `tick` on the same edge while the seconds hold a known non-wrapping value. It passes only if the minute holds the written byte and the seconds read exactly as before, which shows the tick was dropped rather than merged. A separate case checks that a frozen counter ignores a tick that has no write next to it.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FW = 8;

    typedef logic [FW-1:0] fld_t;

    typedef struct packed {
        fld_t century;
        fld_t year;
        fld_t month;
        fld_t day;
        fld_t hour;
        fld_t minute;
        fld_t second;
    } cal_t;

    typedef struct packed {
        logic carry;
        fld_t val;
    } step_t;

    localparam int BIT_FREEZE = 7;
    localparam int BIT_BINARY = 2;
    localparam int BIT_H24    = 1;

    localparam fld_t OFS_SEC  = 8'h00;
    localparam fld_t OFS_MIN  = 8'h02;
    localparam fld_t OFS_HOUR = 8'h04;
    localparam fld_t OFS_DAY  = 8'h07;
    localparam fld_t OFS_MON  = 8'h08;
    localparam fld_t OFS_YEAR = 8'h09;
    localparam fld_t OFS_CTRL = 8'h0B;
    localparam fld_t OFS_CENT = 8'h32;

    localparam fld_t CTRL_RESET = 8'h86;

    // Encode a small integer in the selected format.
    function automatic fld_t enc(input int n, input logic bin);
        if (bin) return FW'(n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    // Decode a field byte into an integer.
    function automatic int dec(input fld_t v, input logic bin);
        if (bin) return int'(v);
        return 10 * int'(v[7:4]) + int'(v[3:0]);
    endfunction

    // One step of a field, carried in its own encoding.
    function automatic step_t bump(input fld_t v, input fld_t top,
                                   input fld_t bottom, input logic bin);
        step_t r;
        if (v == top) begin
            r.carry = 1'b1;
            r.val   = bottom;
        end else if (!bin && v[3:0] == 4'd9) begin
            r.carry = 1'b0;
            r.val   = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.carry = 1'b0;
            r.val   = v + 8'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rtc_addr_latch.sv
module rtc_addr_latch #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (addr_we) addr_q <= addr_in;
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_cal_pkg::*;
(
    input  fld_t month,
    input  fld_t year,
    input  fld_t century,
    input  logic bin,
    output fld_t last_day
);
    int   m_i, y_i, c_i;
    logic leap;

    always_comb begin
        m_i  = dec(month, bin);
        y_i  = dec(year, bin);
        c_i  = dec(century, bin);
        leap = (y_i % 4 == 0) && ((y_i != 0) || (c_i % 4 == 0));
        case (m_i)
            2:             last_day = enc(leap ? 29 : 28, bin);
            4, 6, 9, 11:   last_day = enc(30, bin);
            default:       last_day = enc(31, bin);
        endcase
    end
endmodule

// File: rtl/rtc_advance.sv
module rtc_advance
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    input  logic bin,
    input  logic h24,
    input  fld_t last_day,
    output cal_t nxt
);
    step_t s_st, m_st, h_st, d_st, mo_st, y_st, c_st;
    fld_t  hour_n;
    logic  hour_c;
    logic  pm;

    always_comb begin
        s_st  = bump(cur.second, enc(59, bin), '0, bin);
        m_st  = bump(cur.minute, enc(59, bin), '0, bin);
        d_st  = bump(cur.day, last_day, enc(1, bin), bin);
        mo_st = bump(cur.month, enc(12, bin), enc(1, bin), bin);
        y_st  = bump(cur.year, enc(99, bin), '0, bin);
        c_st  = bump(cur.century, enc(99, bin), '0, bin);
        pm    = cur.hour[7];

        if (h24) begin
            h_st   = bump(cur.hour, enc(23, bin), '0, bin);
            hour_n = h_st.val;
            hour_c = h_st.carry;
        end else begin
            h_st = bump({1'b0, cur.hour[6:0]}, 8'hFF, '0, bin);
            if ({1'b0, cur.hour[6:0]} == enc(12, bin)) begin
                hour_n = {pm, 7'(enc(1, bin))};
                hour_c = 1'b0;
            end else if ({1'b0, cur.hour[6:0]} == enc(11, bin)) begin
                hour_n = {~pm, 7'(enc(12, bin))};
                hour_c = pm;
            end else begin
                hour_n = {pm, 7'b0} | (h_st.val & {1'b0, {7{~h_st.carry}}});
                hour_c = 1'b0;
            end
        end

        nxt        = cur;
        nxt.second = s_st.val;
        if (s_st.carry) begin
            nxt.minute = m_st.val;
            if (m_st.carry) begin
                nxt.hour = hour_n;
                if (hour_c) begin
                    nxt.day = d_st.val;
                    if (d_st.carry) begin
                        nxt.month = mo_st.val;
                        if (mo_st.carry) begin
                            nxt.year = y_st.val;
                            if (y_st.carry)
                                nxt.century = c_st.carry ? '0 : c_st.val;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              addr_we,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_we,
    input  logic [FW-1:0]     data_in,
    output logic [FW-1:0]     data_out
);
    localparam cal_t CAL_RESET = '{century: 8'd20, year: 8'd0, month: 8'd1,
                                   day: 8'd1, hour: 8'd0, minute: 8'd0,
                                   second: 8'd0};

    logic [ADDR_W-1:0] addr_q;
    cal_t              cur_q, nxt;
    fld_t              ctrl_q;
    fld_t              last_day;

    rtc_addr_latch #(.ADDR_W(ADDR_W)) i_latch (
        .clk(clk), .rst(rst), .addr_we(addr_we), .addr_in(addr_in),
        .addr_q(addr_q)
    );

    rtc_month_len i_mlen (
        .month(cur_q.month), .year(cur_q.year), .century(cur_q.century),
        .bin(ctrl_q[BIT_BINARY]), .last_day(last_day)
    );

    rtc_advance i_adv (
        .cur(cur_q), .bin(ctrl_q[BIT_BINARY]), .h24(ctrl_q[BIT_H24]),
        .last_day(last_day), .nxt(nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= CAL_RESET;
            ctrl_q <= CTRL_RESET;
        end else if (data_we) begin
            case (addr_q)
                ADDR_W'(OFS_SEC):  cur_q.second  <= data_in;
                ADDR_W'(OFS_MIN):  cur_q.minute  <= data_in;
                ADDR_W'(OFS_HOUR): cur_q.hour    <= data_in;
                ADDR_W'(OFS_DAY):  cur_q.day     <= data_in;
                ADDR_W'(OFS_MON):  cur_q.month   <= data_in;
                ADDR_W'(OFS_YEAR): cur_q.year    <= data_in;
                ADDR_W'(OFS_CENT): cur_q.century <= data_in;
                ADDR_W'(OFS_CTRL): ctrl_q        <= data_in;
                default: ;
            endcase
        end else if (tick && !ctrl_q[BIT_FREEZE]) begin
            cur_q <= nxt;
        end
    end

    always_comb begin
        case (addr_q)
            ADDR_W'(OFS_SEC):  data_out = cur_q.second;
            ADDR_W'(OFS_MIN):  data_out = cur_q.minute;
            ADDR_W'(OFS_HOUR): data_out = cur_q.hour;
            ADDR_W'(OFS_DAY):  data_out = cur_q.day;
            ADDR_W'(OFS_MON):  data_out = cur_q.month;
            ADDR_W'(OFS_YEAR): data_out = cur_q.year;
            ADDR_W'(OFS_CENT): data_out = cur_q.century;
            ADDR_W'(OFS_CTRL): data_out = ctrl_q;
            default:           data_out = '0;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              data_we,
    input logic [FW-1:0]     data_in,
    input logic [ADDR_W-1:0] addr_q,
    input logic [FW-1:0]     ctrl_q,
    input logic [7*FW-1:0]   time_bits
);
    // R1
    sec_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we && addr_q == ADDR_W'(OFS_SEC)) |=> time_bits[7:0] == $past(data_in));

    // R3
    idle_holds_time_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !data_we) |=> $stable(time_bits));

    // R10
    freeze_holds_time_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[BIT_FREEZE] && !data_we) |=> $stable(time_bits));

    // R7
    hour12_never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q[BIT_H24] && tick && !ctrl_q[BIT_FREEZE] && !data_we
         && time_bits[22:16] != 7'd0) |=> time_bits[22:16] != 7'd0);
endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk(clk), .rst(rst), .tick(tick), .data_we(data_we), .data_in(data_in),
    .addr_q(addr_q), .ctrl_q(ctrl_q), .time_bits(cur_q)
);

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    import rtc_cal_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       addr_we = 1'b0;
    logic [7:0] addr_in = '0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = '0;
    logic [7:0] data_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_calendar #(.ADDR_W(8)) i_rtc_calendar (
        .clk(clk), .rst(rst), .tick(tick), .addr_we(addr_we),
        .addr_in(addr_in), .data_we(data_we), .data_in(data_in),
        .data_out(data_out)
    );

    // {control, start cent..sec, expected cent..sec}
    localparam int NV = 14;
    localparam logic [119:0] VECS [NV] = '{
        {8'h06, 56'h13460101000000, 56'h13460101000001}, // R5 binary second
        {8'h00, 56'h20240101115959, 56'h20240101920000}, // R7 11AM -> 12PM
        {8'h00, 56'h20240101925959, 56'h20240101810000}, // R7 12PM -> 1PM
        {8'h00, 56'h20240315915959, 56'h20240316120000}, // R7 11PM -> 12AM
        {8'h02, 56'h20240228235959, 56'h20240229000000}, // R8 leap
        {8'h02, 56'h20230228235959, 56'h20230301000000}, // R8 common
        {8'h02, 56'h20000228235959, 56'h20000229000000}, // R8 century leap
        {8'h02, 56'h19000228235959, 56'h19000301000000}, // R8 century common
        {8'h06, 56'h13630C1F173B3B, 56'h14000101000000}, // R9 binary full roll
        {8'h02, 56'h20240430235959, 56'h20240501000000}, // R8 30-day month
        {8'h02, 56'h20240101095959, 56'h20240101100000}, // R4 digit carry
        {8'h04, 56'h141801010B3B3B, 56'h141801018C0000}, // R7 binary 12h
        {8'h02, 56'h99991231235959, 56'h00000101000000}, // R9 R6 full BCD roll
        {8'h02, 56'h20240101000009, 56'h20240101000010}  // R4 seconds digit
    };
    localparam logic [7:0] OFS [7] = '{8'h32, 8'h09, 8'h08, 8'h07, 8'h04, 8'h02, 8'h00};

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic put_addr(input logic [7:0] a);
        @(negedge clk); addr_we = 1'b1; addr_in = a;
        @(negedge clk); addr_we = 1'b0;
    endtask

    task automatic put_data(input logic [7:0] d);
        @(negedge clk); data_we = 1'b1; data_in = d;
        @(negedge clk); data_we = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        put_addr(a);
        put_data(d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        put_addr(a);
        #1 d = data_out;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2 reset state
        rd(8'h0B, v); check("R2 ctrl", v, 8'h86);
        rd(8'h00, v); check("R2 second", v, 8'h00);
        rd(8'h07, v); check("R2 day", v, 8'h01);
        rd(8'h32, v); check("R2 century", v, 8'd20);

        // R1 unmapped offset reads zero and stores nothing
        wr(8'h05, 8'h55);
        rd(8'h05, v); check("R1 unmapped", v, 8'h00);
        rd(8'h00, v); check("R1 second untouched", v, 8'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  ctl;
            logic [55:0] st, ex;
            ctl = VECS[i][119:112];
            st  = VECS[i][111:56];
            ex  = VECS[i][55:0];
            wr(8'h0B, ctl | 8'h80);
            for (int k = 0; k < 7; k++) wr(OFS[k], st[55 - 8*k -: 8]);
            wr(8'h0B, ctl);
            pulse_tick();
            for (int k = 0; k < 7; k++) begin
                rd(OFS[k], v);
                check($sformatf("R3 vector %0d offset %02h", i, OFS[k]), v, ex[55 - 8*k -: 8]);
            end
        end

        // R10 freeze ignores tick
        wr(8'h0B, 8'h86);
        wr(8'h00, 8'h10);
        pulse_tick();
        rd(8'h00, v); check("R10 frozen second", v, 8'h10);

        // R3 release from 00:00:00
        wr(8'h00, 8'h00); wr(8'h02, 8'h00); wr(8'h04, 8'h00);
        wr(8'h0B, 8'h06);
        pulse_tick();
        rd(8'h00, v); check("R3 first update", v, 8'h01);
        pulse_tick();
        rd(8'h00, v); check("R3 second update", v, 8'h02);

        // R11 write and tick in the same cycle: write kept, tick dropped
        put_addr(8'h02);
        @(negedge clk); data_we = 1'b1; data_in = 8'h05; tick = 1'b1;
        @(negedge clk); data_we = 1'b0; tick = 1'b0;
        rd(8'h02, v); check("R11 minute written", v, 8'h05);
        rd(8'h00, v); check("R11 second held", v, 8'h02);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule